// File: doc/BRIEF.md
# Smart card character serializer

This block moves single characters between a byte-wide bus interface and the one-wire data line of an asynchronous smart card link. It runs half duplex. A character on the line is a low start bit, eight data bits and a parity bit, followed by a high guard period of two bit times. Every bit lasts a programmable number of system clocks. The data line appears as three separate signals: a line input, a line output and an output enable. The enable is held low whenever the block is not driving the line.

Two control bits set the coding convention. One bit picks the order in which data bits are placed on the line. The other bit inverts the data bits. Neither control touches the parity bit. Parity is always computed over the data bits as they appear on the wire, and a separate input picks even or odd parity. An inverse-convention card is served by setting both controls and choosing odd parity. Software writes a byte to start a transmission. It polls a status byte for busy, receive-full and a sticky parity-error flag.

Top module: `sc_char_xcvr`

## Requirements
- R1: Address 0 is the control register. Bit 0 is enable, bit 2 is data inversion and bit 3 selects most-significant-bit first. Bits 7 to 4 and bit 1 always read 0, whatever is written to them. Address 1 reads back the last byte written for transmission, and address 2 reads the last received byte. Address 3 reads status: bit 0 busy, bit 1 receive-full, bit 2 parity error, all other bits 0. After reset every register reads 0, lineOut is 1 and lineOe is 0.
- R2: When standby is high at a rising clock edge, the enable, inversion and order bits clear to 0 and any character in progress is abandoned. From the next cycle lineOe is 0.
- R3: A write to address 1 while enabled and idle starts a character. From the rising edge that takes the write, lineOe is 1 for 10·N cycles, where N is baudDiv (N ≥ 4). During that time lineOut carries, for N cycles each, the low start bit, the eight data bits and the parity bit. For the next 2·N cycles lineOe is 0 and lineOut is 1. Busy reads 1 for exactly 12·N cycles from that edge. Whenever lineOe is 0, lineOut is 1.
- R4: With the order bit at 0, the first data bit on the line is byte bit 0, and received bits fill the byte from bit 0 upward. With the order bit at 1, both directions use bit 7 first.
- R5: With the inversion bit at 1, the byte is complemented before it is serialized, and assembled received data is complemented before it is stored. With the inversion bit at 0, data passes unchanged. The parity bit is the XOR of the eight line data bits, XORed with oddParity (0 gives even parity, 1 gives odd). The parity bit is never inverted.
- R6: While enabled and idle, a falling edge on lineIn starts reception. lineIn passes a two-stage synchronizer, and each bit is sampled at the middle of its period. The received byte, receive-full (set) and parity error (set on mismatch, sticky) all update at the rising edge 9·N + N/2 + 4 after the line falls, for even N. Writing 1 to status bit 1 or bit 2 clears that flag. If a flag is set and cleared in the same cycle, the set wins.
- R7: While the enable bit is 0, lineOe is 0. Writing 0 to the enable bit during a character abandons the character: busy and lineOe are 0 from the next cycle. A write to address 1 starts nothing and lineIn activity stores nothing.
- R8: A write to address 1 while busy, whether transmitting or receiving, starts no character and does not change the character in progress. The written byte still reads back at address 1.
- R9: If the start bit reads high at its mid-bit sample, the receiver returns to idle without storing anything or setting any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Clears the control bits and abandons any transfer |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational on addr) |
| baudDiv | input | DIV_W | Bit period in system clocks |
| oddParity | input | 1 | 1 selects odd parity, 0 even |
| lineIn | input | 1 | Card data line as seen at the pad |
| lineOut | output | 1 | Value driven onto the data line |
| lineOe | output | 1 | High while the block drives the line |

## Verification
Two events can fall in the same clock cycle. One is a received character storing its parity result and setting receive-full. The other is a software write of 1s to the status register that clears those same flags. The bench sends a character with wrong parity and computes, from the synchronizer and mid-bit latencies, the exact edge where the store lands. It places the clearing write in that cycle. The set must win, so both flags must then read 1; a later clearing write must then bring them to 0.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int GUARD_BITS = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TXD  = 2'd1;
  localparam logic [1:0] ADDR_RXD  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTL_EN  = 0;
  localparam int CTL_INV = 2;
  localparam int CTL_MSB = 3;

  localparam int STS_BUSY = 0;
  localparam int STS_FULL = 1;
  localparam int STS_PERR = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } scStateT;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic startRx;
    logic sampleRx;
    logic storeRx;
    logic abort;
  } scStrobeT;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 standby,
  input  logic                 wrEn,
  input  logic [1:0]           addr,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic [DIV_W-1:0]     baudDiv,
  input  logic                 rxFall,
  input  logic                 rxBit,
  input  logic                 parityBad,
  input  logic [DATA_BITS-1:0] rxData,
  output scStrobeT             strb,
  output logic                 enable,
  output logic                 invert,
  output logic                 msbFirst,
  output logic                 busy,
  output logic                 lineOe,
  output logic                 fullFlag,
  output logic                 perrFlag,
  output logic [DATA_BITS-1:0] rdData
);
  localparam int TOTAL_BITS = FRAME_BITS + GUARD_BITS;
  localparam int BIT_W      = $clog2(TOTAL_BITS);
  localparam logic [BIT_W-1:0] LAST_FRAME = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] LAST_ALL   = BIT_W'(TOTAL_BITS - 1);
  localparam logic [BIT_W-1:0] FIRST_DAT  = BIT_W'(1);
  localparam logic [BIT_W-1:0] LAST_DAT   = BIT_W'(DATA_BITS);
  localparam logic [BIT_W-1:0] NUM_FRAME  = BIT_W'(FRAME_BITS);

  logic enQ, invQ, msbQ;
  logic fullQ, perrQ;
  logic [DATA_BITS-1:0] txByteQ;
  scStateT stateQ;
  logic [DIV_W-1:0] cntQ;
  logic [BIT_W-1:0] bitQ;

  logic ctrlWr, txWr, statWr;
  logic enNext, kill, isIdle, txGo, rxGo;
  logic bitEnd, midHit;
  logic [DIV_W-1:0] lastCnt, midCnt;

  always_comb begin
    ctrlWr  = wrEn && (addr == ADDR_CTRL);
    txWr    = wrEn && (addr == ADDR_TXD);
    statWr  = wrEn && (addr == ADDR_STAT);
    enNext  = standby ? 1'b0 : (ctrlWr ? wrData[CTL_EN] : enQ);
    kill    = !enNext;
    isIdle  = (stateQ == ST_IDLE);
    txGo    = isIdle && enQ && !kill && txWr;
    rxGo    = isIdle && enQ && !kill && !txWr && rxFall;
    lastCnt = baudDiv - 1'b1;
    midCnt  = baudDiv >> 1;
    bitEnd  = (cntQ == lastCnt);
    midHit  = (cntQ == midCnt);
  end

  always_comb begin
    strb          = '0;
    strb.loadTx   = txGo;
    strb.startRx  = rxGo;
    strb.abort    = kill;
    strb.shiftTx  = !kill && (stateQ == ST_TX) && bitEnd;
    strb.sampleRx = !kill && (stateQ == ST_RX) && midHit &&
                    (bitQ >= FIRST_DAT) && (bitQ <= LAST_DAT);
    strb.storeRx  = !kill && (stateQ == ST_RX) && midHit && (bitQ == LAST_FRAME);
  end

  // control register: only the three defined bits hold state
  always_ff @(posedge clk) begin
    if (!rstN || standby) begin
      enQ  <= 1'b0;
      invQ <= 1'b0;
      msbQ <= 1'b0;
    end else if (ctrlWr) begin
      enQ  <= wrData[CTL_EN];
      invQ <= wrData[CTL_INV];
      msbQ <= wrData[CTL_MSB];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txByteQ <= '0;
    else if (txWr) txByteQ <= wrData;
  end

  // sticky flags, a set from the receiver beats a software clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ <= 1'b0;
      perrQ <= 1'b0;
    end else begin
      if (strb.storeRx) fullQ <= 1'b1;
      else if (statWr && wrData[STS_FULL]) fullQ <= 1'b0;
      if (strb.storeRx && parityBad) perrQ <= 1'b1;
      else if (statWr && wrData[STS_PERR]) perrQ <= 1'b0;
    end
  end

  // sequencer: bit period counter and bit index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      bitQ   <= '0;
    end else if (kill) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      bitQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          cntQ <= '0;
          bitQ <= '0;
          if (txGo) stateQ <= ST_TX;
          else if (rxGo) stateQ <= ST_RX;
        end
        ST_TX: begin
          if (bitEnd) begin
            cntQ <= '0;
            if (bitQ == LAST_ALL) stateQ <= ST_IDLE;
            else bitQ <= bitQ + 1'b1;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        ST_RX: begin
          if (midHit && (bitQ == '0) && rxBit) begin
            stateQ <= ST_IDLE;
          end else if (midHit && (bitQ == LAST_FRAME)) begin
            stateQ <= ST_IDLE;
          end else if (bitEnd) begin
            cntQ <= '0;
            bitQ <= bitQ + 1'b1;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    enable   = enQ;
    invert   = invQ;
    msbFirst = msbQ;
    busy     = !isIdle;
    lineOe   = (stateQ == ST_TX) && (bitQ < NUM_FRAME);
    fullFlag = fullQ;
    perrFlag = perrQ;
    unique case (addr)
      ADDR_CTRL: begin
        rdData          = '0;
        rdData[CTL_EN]  = enQ;
        rdData[CTL_INV] = invQ;
        rdData[CTL_MSB] = msbQ;
      end
      ADDR_TXD: rdData = txByteQ;
      ADDR_RXD: rdData = rxData;
      default: begin
        rdData           = '0;
        rdData[STS_BUSY] = !isIdle;
        rdData[STS_FULL] = fullQ;
        rdData[STS_PERR] = perrQ;
      end
    endcase
  end
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  scStrobeT             strb,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 invert,
  input  logic                 msbFirst,
  input  logic                 oddParity,
  input  logic                 lineIn,
  output logic                 rxFall,
  output logic                 rxBit,
  output logic                 parityBad,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 lineOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic rxPrevQ;
  logic rxS;
  logic [FRAME_BITS-1:0] txShiftQ;
  logic [DATA_BITS-1:0] rxShiftQ, rxDataQ;
  logic [DATA_BITS-1:0] txCode, txLine;
  logic txPar;

  function automatic logic [DATA_BITS-1:0] flipOrder(input logic [DATA_BITS-1:0] v);
    logic [DATA_BITS-1:0] r;
    for (int i = 0; i < DATA_BITS; i++) r[i] = v[DATA_BITS-1-i];
    return r;
  endfunction

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else syncQ <= lineIn;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
    end
  endgenerate

  assign rxS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) rxPrevQ <= 1'b1;
    else rxPrevQ <= rxS;
  end

  // transmit: data shaped for the line, parity over the line form
  always_comb begin
    txCode = invert ? ~wrData : wrData;
    txLine = msbFirst ? flipOrder(txCode) : txCode;
    txPar  = (^txLine) ^ oddParity;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.abort) txShiftQ <= '1;
    else if (strb.loadTx) txShiftQ <= {txPar, txLine, 1'b0};
    else if (strb.shiftTx) txShiftQ <= {1'b1, txShiftQ[FRAME_BITS-1:1]};
  end

  // receive: assemble in arrival order, shape on store
  always_ff @(posedge clk) begin
    if (!rstN || strb.startRx) rxShiftQ <= '0;
    else if (strb.sampleRx) begin
      if (msbFirst) rxShiftQ <= {rxShiftQ[DATA_BITS-2:0], rxS};
      else rxShiftQ <= {rxS, rxShiftQ[DATA_BITS-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxDataQ <= '0;
    else if (strb.storeRx) rxDataQ <= invert ? ~rxShiftQ : rxShiftQ;
  end

  always_comb begin
    rxFall    = rxPrevQ && !rxS;
    rxBit     = rxS;
    parityBad = ((^rxShiftQ) ^ rxS) != oddParity;
    rxData    = rxDataQ;
    lineOut   = txShiftQ[0];
  end
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             standby,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             oddParity,
  input  logic             lineIn,
  output logic             lineOut,
  output logic             lineOe
);
  scStrobeT strb;
  logic enable, invert, msbFirst, busy, fullFlag, perrFlag;
  logic rxFall, rxBit, parityBad;
  logic [DATA_BITS-1:0] rxData;

  sc_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .baudDiv(baudDiv), .rxFall(rxFall), .rxBit(rxBit),
    .parityBad(parityBad), .rxData(rxData), .strb(strb), .enable(enable),
    .invert(invert), .msbFirst(msbFirst), .busy(busy), .lineOe(lineOe),
    .fullFlag(fullFlag), .perrFlag(perrFlag), .rdData(rdData)
  );

  sc_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .invert(invert),
    .msbFirst(msbFirst), .oddParity(oddParity), .lineIn(lineIn),
    .rxFall(rxFall), .rxBit(rxBit), .parityBad(parityBad), .rxData(rxData),
    .lineOut(lineOut)
  );
endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk
  import sc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       standby,
  input logic [1:0] addr,
  input logic [7:0] rdData,
  input logic       lineOe,
  input logic       lineOut,
  input logic       enable,
  input logic       invert,
  input logic       msbFirst,
  input logic       busy,
  input scStrobeT   strb,
  input logic       parityBad,
  input logic       fullFlag,
  input logic       perrFlag
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_CTRL) |-> (rdData[7:4] == 4'd0 && !rdData[1])); // R1
  AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (!enable && !invert && !msbFirst && !lineOe)); // R2
  AST_RELEASED_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !lineOe |-> lineOut); // R3
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> !lineOut); // R3
  AST_DRIVE_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    lineOe |-> busy); // R3
  AST_FULL_ON_STORE: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeRx |=> fullFlag); // R6
  AST_PERR_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.storeRx && parityBad) |=> perrFlag); // R6
  AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    lineOe |-> enable); // R7
endmodule

bind sc_char_xcvr sc_char_xcvr_chk u_chk (
  .clk(clk), .rstN(rstN), .standby(standby), .addr(addr), .rdData(rdData),
  .lineOe(lineOe), .lineOut(lineOut), .enable(enable), .invert(invert),
  .msbFirst(msbFirst), .busy(busy), .strb(strb), .parityBad(parityBad),
  .fullFlag(fullFlag), .perrFlag(perrFlag)
);

// File: tb/sc_char_xcvr_tb.sv
`timescale 1ns/1ps
module sc_char_xcvr_tb;
  localparam int DIV_W = 12;
  localparam int SYNC  = 2;

  logic clk = 1'b0, rstN = 1'b0, standby = 1'b0, wrEn = 1'b0;
  logic oddParity = 1'b0, lineIn = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [DIV_W-1:0] baudDiv = 12'd8;
  wire [7:0] rdData;
  wire lineOut, lineOe;

  int nChecks = 0, nFails = 0;
  int nb = 8;
  bit modelOn = 1'b0;
  bit curInv = 1'b0, curMsb = 1'b0;
  logic [1:0] lineQ[$];   // expected {lineOe, lineOut} per cycle
  logic [7:0] v, prevRx;

  always #2 clk = ~clk;

  sc_char_xcvr #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .baudDiv(baudDiv), .oddParity(oddParity),
    .lineIn(lineIn), .lineOut(lineOut), .lineOe(lineOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  // reference of the line, compared every cycle
  always @(negedge clk) begin : lineModel
    logic [1:0] e;
    if (modelOn) begin
      if (lineQ.size() > 0) e = lineQ.pop_front();
      else e = 2'b01;
      check({lineOe, lineOut} == e, "R3 line", {lineOe, lineOut}, e);
    end
  end

  function automatic logic [7:0] lineBits(input logic [7:0] d, input bit inv, input bit msb);
    logic [7:0] c, r;
    c = inv ? ~d : d;
    for (int i = 0; i < 8; i++) r[i] = msb ? c[7-i] : c[i];
    return r;
  endfunction

  task automatic pushFrame(input logic [7:0] d);
    logic [7:0] r;
    logic p;
    r = lineBits(d, curInv, curMsb);
    p = (^r) ^ oddParity;
    for (int c = 0; c < nb; c++) lineQ.push_back(2'b10);
    for (int i = 0; i < 8; i++)
      for (int c = 0; c < nb; c++) lineQ.push_back({1'b1, r[i]});
    for (int c = 0; c < nb; c++) lineQ.push_back({1'b1, p});
    for (int c = 0; c < 2 * nb; c++) lineQ.push_back(2'b01);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    if (a == 2'd0 && !d[0]) lineQ.delete();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setCtrl(input logic [7:0] d);
    wr(2'd0, d);
    curInv = d[2];
    curMsb = d[3];
  endtask

  task automatic txStart(input logic [7:0] d);
    @(negedge clk);
    addr = 2'd1; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    pushFrame(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdNow(input logic [1:0] a, output logic [7:0] q);
    addr = a;
    #1;
    q = rdData;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    @(negedge clk);
    rdNow(a, q);
  endtask

  task automatic sendFrame(input logic [7:0] r, input logic p, input int n);
    logic [9:0] f;
    f = {p, r, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      lineIn = f[i];
      repeat (n - 1) @(negedge clk);
    end
    @(negedge clk);
    lineIn = 1'b1;
    repeat (2 * n - 1) @(negedge clk);
  endtask

  task automatic rxSend(input logic [7:0] d, input bit badPar);
    logic [7:0] r;
    logic p;
    r = lineBits(d, curInv, curMsb);
    p = (^r) ^ oddParity ^ badPar;
    sendFrame(r, p, nb);
  endtask

  task automatic waitIdle();
    repeat (13 * nb) @(negedge clk);
  endtask

  task automatic busyWindow(input string tag);
    logic [7:0] s;
    rdNow(2'd3, s);
    check(s[0] == 1'b1, tag, s[0], 1);
    repeat (12 * nb - 1) @(negedge clk);
    rdNow(2'd3, s);
    check(s[0] == 1'b1, tag, s[0], 1);
    @(negedge clk);
    rdNow(2'd3, s);
    check(s[0] == 1'b0, tag, s[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelOn = 1'b1;

    // R1 reset state
    rd(2'd0, v); check(v == 8'h00, "R1 reset ctrl", v, 8'h00);
    rd(2'd3, v); check(v == 8'h00, "R1 reset status", v, 8'h00);
    check(lineOe == 1'b0 && lineOut == 1'b1, "R1 reset line", {lineOe, lineOut}, 2'b01);

    // R1 reserved bits
    setCtrl(8'hFF);
    rd(2'd0, v); check(v == 8'h0D, "R1 reserved", v, 8'h0D);

    // R3 R4 LSB first, plain
    setCtrl(8'h01);
    txStart(8'hA5);
    busyWindow("R3 busy");
    waitIdle();

    // R4 MSB first
    setCtrl(8'h09);
    txStart(8'h3C);
    waitIdle();

    // R5 inversion, odd parity, then inverse convention
    oddParity = 1'b1;
    setCtrl(8'h05);
    txStart(8'h0F);
    waitIdle();
    setCtrl(8'h0D);
    txStart(8'h3F);
    waitIdle();
    oddParity = 1'b0;

    // R8 write while transmitting
    setCtrl(8'h01);
    txStart(8'h81);
    repeat (3 * nb) @(negedge clk);
    wr(2'd1, 8'h55);
    rd(2'd1, v); check(v == 8'h55, "R8 byte readback", v, 8'h55);
    waitIdle();

    // R6 R4 receive LSB first
    rxSend(8'h5A, 1'b0);
    rd(2'd2, v); check(v == 8'h5A, "R6 rx byte", v, 8'h5A);
    rd(2'd3, v); check(v == 8'h02, "R6 rx flags", v, 8'h02);
    wr(2'd3, 8'h02);
    rd(2'd3, v); check(v == 8'h00, "R6 full clear", v, 8'h00);

    // R5 receive inverse convention
    oddParity = 1'b1;
    setCtrl(8'h0D);
    rxSend(8'hC6, 1'b0);
    rd(2'd2, v); check(v == 8'hC6, "R5 rx inverse", v, 8'hC6);
    rd(2'd3, v); check(v == 8'h02, "R5 rx parity ok", v, 8'h02);
    wr(2'd3, 8'h02);
    oddParity = 1'b0;

    // R4 receive MSB first
    setCtrl(8'h09);
    rxSend(8'h1E, 1'b0);
    rd(2'd2, v); check(v == 8'h1E, "R4 rx msb", v, 8'h1E);
    wr(2'd3, 8'h02);

    // R6 parity error, sticky, write-1 clear
    rxSend(8'h33, 1'b1);
    rd(2'd3, v); check(v == 8'h06, "R6 perr set", v, 8'h06);
    wr(2'd3, 8'h04);
    rd(2'd3, v); check(v == 8'h02, "R6 perr clear", v, 8'h02);
    wr(2'd3, 8'h02);

    // R6 set and clear in the same cycle
    fork
      rxSend(8'h44, 1'b1);
      begin
        repeat (SYNC + 2 + 9 * nb + nb / 2) @(negedge clk);
        addr = 2'd3; wrData = 8'h06; wrEn = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wrEn = 1'b0;
      end
    join
    rd(2'd3, v); check(v == 8'h06, "R6 set wins", v, 8'h06);
    rd(2'd2, v); check(v == 8'h44, "R6 collide byte", v, 8'h44);
    prevRx = v;
    wr(2'd3, 8'h06);
    rd(2'd3, v); check(v == 8'h00, "R6 both clear", v, 8'h00);

    // R9 false start
    setCtrl(8'h01);
    @(negedge clk); lineIn = 1'b0;
    repeat (2) @(negedge clk);
    lineIn = 1'b1;
    repeat (12 * nb) @(negedge clk);
    rd(2'd3, v); check(v == 8'h00, "R9 no store", v, 8'h00);
    rd(2'd2, v); check(v == prevRx, "R9 rx kept", v, prevRx);

    // R7 disable mid-character
    txStart(8'hE7);
    repeat (4 * nb) @(negedge clk);
    setCtrl(8'h00);
    rd(2'd3, v); check(v[0] == 1'b0, "R7 abandon", v[0], 0);
    wr(2'd1, 8'h77);
    repeat (12 * nb) @(negedge clk);
    rxSend(8'h99, 1'b0);
    rd(2'd3, v); check(v == 8'h00, "R7 rx ignored", v, 8'h00);
    rd(2'd2, v); check(v == prevRx, "R7 rx kept", v, prevRx);

    // R2 standby
    setCtrl(8'h0D);
    txStart(8'h12);
    repeat (2 * nb) @(negedge clk);
    standby = 1'b1;
    @(posedge clk);
    lineQ.delete();
    @(negedge clk);
    standby = 1'b0;
    curInv = 1'b0; curMsb = 1'b0;
    rd(2'd0, v); check(v == 8'h00, "R2 ctrl cleared", v, 8'h00);
    rd(2'd3, v); check(v[0] == 1'b0, "R2 abandon", v[0], 0);

    // R8 write while receiving
    setCtrl(8'h01);
    fork
      rxSend(8'h6B, 1'b0);
      begin
        repeat (3 * nb) @(negedge clk);
        wr(2'd1, 8'hC3);
      end
    join
    rd(2'd2, v); check(v == 8'h6B, "R8 rx intact", v, 8'h6B);
    rd(2'd3, v); check(v == 8'h02, "R8 no tx start", v, 8'h02);
    wr(2'd3, 8'h02);

    // R3 other bit period
    @(negedge clk);
    baudDiv = 12'd5;
    nb = 5;
    txStart(8'h96);
    busyWindow("R3 busy n5");
    waitIdle();

    summary();
  end
endmodule